// File: doc/BRIEF.md
# Wireless Link Control Sequencer

This block sits between an FPGA's byte-level UART logic and a serial wireless module that runs in transparent mode. It owns the module's two control pins. The first is an active-low reset, which the block holds low after power-up and whenever a reset is requested. The second is an active-low disconnect pin, which the block pulses low on request to drop the radio link. All pulse widths and waiting times are derived from a clock-frequency parameter.

The module reports whether a link exists on a status input: low means no link, high means a peer is attached. The block brings this input into the clock domain and filters it before raising its `connected` flag. The flag stays low until a settling time has passed after each module reset.

While `connected` is high, the block forwards bytes unchanged in both directions. Local bytes go to the module's transmit path, and bytes received from the module go to the local side. While `connected` is low, bytes are discarded. There is no flow control and no buffering.

Top module: `wlink_seq`

## Requirements
- R1: After `rst_n` is released, `mod_rst_n` stays low for exactly RST_US worth of clock cycles (default 6000 us), then goes high.
- R2: A one-cycle `rst_req` while the sequencer is idle drives `mod_rst_n` low for exactly the reset pulse length, starting at the next clock edge. `connected` is 0 by the second cycle of that pulse.
- R3: A one-cycle `disc_req` while the sequencer is idle drives `mod_disc_n` low for exactly DISC_US worth of cycles (default 200000 us), then returns it high.
- R4: Any `rst_req` or `disc_req` that arrives while either pulse is active is ignored: the active pulse keeps its length and no second pulse starts. When both requests arrive together while idle, only the reset pulse starts.
- R5: `busy` is 1 exactly while `mod_rst_n` or `mod_disc_n` is low. The two pins are never low at the same time.
- R6: `connected` stays 0 for SETTLE_US worth of cycles (default 100000 us) after `mod_rst_n` rises, regardless of `mod_link`.
- R7: `mod_link` passes through a two-flop synchronizer. After settling, `connected` takes the synchronized value only after that value has differed from `connected` for DEB_US worth of consecutive cycles (default 1000 us). Shorter glitches leave `connected` unchanged.
- R8: While `connected` is 1, a byte presented with `loc_tx_valid` appears on `mod_tx_valid`/`mod_tx_data` one cycle later, unchanged. A byte presented with `mod_rx_valid` appears on `loc_rx_valid`/`loc_rx_data` one cycle later, unchanged.
- R9: A byte presented in either direction while `connected` is 0 is dropped: no valid ever appears for it on the opposite side.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Request a module reset pulse |
| disc_req | input | 1 | Request a disconnect pulse |
| mod_rst_n | output | 1 | Active-low reset to the wireless module |
| mod_disc_n | output | 1 | Active-low disconnect pin of the module |
| mod_link | input | 1 | Link status from the module (high = linked), asynchronous |
| connected | output | 1 | Filtered link flag |
| busy | output | 1 | A reset or disconnect pulse is active |
| loc_tx_valid | input | 1 | Local byte for the module is valid |
| loc_tx_data | input | DW | Local byte for the module |
| mod_tx_valid | output | 1 | Byte to the module's UART transmitter is valid |
| mod_tx_data | output | DW | Byte to the module's UART transmitter |
| mod_rx_valid | input | 1 | Byte from the module's UART receiver is valid |
| mod_rx_data | input | DW | Byte from the module's UART receiver |
| loc_rx_valid | output | 1 | Byte for the local side is valid |
| loc_rx_data | output | DW | Byte for the local side |

## Verification
A wrong pulse counter shows up as a pin low time that differs from the programmed length. A wrong pulse state shows up as a pulse restarting or stretching when a second request arrives. In both cases the fault is visible on the release edge of the pulse, milliseconds after it started. A broken settle or debounce state shows up as `connected` rising too early or too late after the module reset ends, or following a short glitch on `mod_link`. This is visible within a few cycles of the expected edge. A lane enable that is out of step with `connected` shows up on the very next cycle, as a forwarded byte while disconnected or a missing one while connected.

// File: rtl/wlink_pkg.sv
package wlink_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_RST  = 2'd1,
        PS_DISC = 2'd2
    } pulse_e;

    // Convert a duration in microseconds to a cycle count, at least one.
    function automatic int us_to_cyc(longint hz, longint us);
        longint c;
        c = (hz * us) / 64'd1_000_000;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/wlink_pulse_ctl.sv
module wlink_pulse_ctl
    import wlink_pkg::*;
#(
    parameter int RST_CYC  = 600,
    parameter int DISC_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_req,
    input  logic disc_req,
    output logic mod_rst_n,
    output logic mod_disc_n,
    output logic busy
);
    localparam int MAXC = (RST_CYC > DISC_CYC) ? RST_CYC : DISC_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        pulse_e        st;
        logic [CW-1:0] cnt;
        logic          rst_n;
        logic          disc_n;
    } pc_t;

    pc_t pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        case (pc_q.st)
            PS_IDLE: begin
                if (rst_req) begin
                    pc_d.st    = PS_RST;
                    pc_d.cnt   = '0;
                    pc_d.rst_n = 1'b0;
                end else if (disc_req) begin
                    pc_d.st     = PS_DISC;
                    pc_d.cnt    = '0;
                    pc_d.disc_n = 1'b0;
                end
            end
            PS_RST: begin
                if (pc_q.cnt == CW'(RST_CYC - 1)) begin
                    pc_d.st    = PS_IDLE;
                    pc_d.cnt   = '0;
                    pc_d.rst_n = 1'b1;
                end else begin
                    pc_d.cnt = pc_q.cnt + 1'b1;
                end
            end
            PS_DISC: begin
                if (pc_q.cnt == CW'(DISC_CYC - 1)) begin
                    pc_d.st     = PS_IDLE;
                    pc_d.cnt    = '0;
                    pc_d.disc_n = 1'b1;
                end else begin
                    pc_d.cnt = pc_q.cnt + 1'b1;
                end
            end
            default: begin
                pc_d.st     = PS_IDLE;
                pc_d.cnt    = '0;
                pc_d.rst_n  = 1'b1;
                pc_d.disc_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q.st     <= PS_RST;
            pc_q.cnt    <= '0;
            pc_q.rst_n  <= 1'b0;
            pc_q.disc_n <= 1'b1;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign mod_rst_n  = pc_q.rst_n;
    assign mod_disc_n = pc_q.disc_n;
    assign busy       = ~(pc_q.rst_n & pc_q.disc_n);

    // Independent low-time counters for the pulse width checks.
    logic [CW:0] rst_low_q, disc_low_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_low_q  <= '0;
            disc_low_q <= '0;
        end else begin
            rst_low_q  <= mod_rst_n  ? '0 : rst_low_q + 1'b1;
            disc_low_q <= mod_disc_n ? '0 : disc_low_q + 1'b1;
        end
    end

    assert_rst_width_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_rst_n) |-> rst_low_q == (CW+1)'(RST_CYC));

    assert_disc_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_disc_n) |-> disc_low_q == (CW+1)'(DISC_CYC));

    assert_no_disc_in_rst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_rst_n |=> mod_disc_n);

    assert_pins_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mod_rst_n && !mod_disc_n));

endmodule

// File: rtl/wlink_link_mon.sv
module wlink_link_mon #(
    parameter int SETTLE_CYC = 10000,
    parameter int DEB_CYC    = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_in_rst,
    input  logic link_raw,
    output logic connected
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam int DW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          settled;
        logic [SW-1:0] scnt;
        logic [DW-1:0] dcnt;
        logic          conn;
    } lm_t;

    lm_t lm_d, lm_q;

    always_comb begin
        lm_d    = lm_q;
        lm_d.s1 = link_raw;
        lm_d.s2 = lm_q.s1;
        if (mod_in_rst) begin
            lm_d.settled = 1'b0;
            lm_d.scnt    = '0;
            lm_d.dcnt    = '0;
            lm_d.conn    = 1'b0;
        end else if (!lm_q.settled) begin
            if (lm_q.scnt == SW'(SETTLE_CYC - 1)) begin
                lm_d.settled = 1'b1;
                lm_d.scnt    = '0;
            end else begin
                lm_d.scnt = lm_q.scnt + 1'b1;
            end
        end else if (lm_q.s2 != lm_q.conn) begin
            if (lm_q.dcnt == DW'(DEB_CYC - 1)) begin
                lm_d.conn = lm_q.s2;
                lm_d.dcnt = '0;
            end else begin
                lm_d.dcnt = lm_q.dcnt + 1'b1;
            end
        end else begin
            lm_d.dcnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lm_q <= '0;
        end else begin
            lm_q <= lm_d;
        end
    end

    assign connected = lm_q.conn;

    assert_clear_on_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mod_in_rst |=> !connected);

    assert_settle_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        connected |-> lm_q.settled);

    assert_rise_follows_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(connected) |-> $past(lm_q.s2));

    assert_fall_follows_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(connected) && !$past(mod_in_rst) |-> !$past(lm_q.s2));

endmodule

// File: rtl/wlink_lane.sv
module wlink_lane #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          in_v,
    input  logic [DW-1:0] in_d,
    output logic          out_v,
    output logic [DW-1:0] out_d
);
    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
    } ln_t;

    ln_t ln_d, ln_q;

    always_comb begin
        ln_d   = ln_q;
        ln_d.v = in_v & en;
        if (in_v && en) ln_d.d = in_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    assign out_v = ln_q.v;
    assign out_d = ln_q.d;

    assert_byte_intact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_v |-> $past(in_v) && out_d == $past(in_d));

    assert_drop_when_down_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en && in_v |=> !out_v);

endmodule

// File: rtl/wlink_seq.sv
module wlink_seq
    import wlink_pkg::*;
#(
    parameter longint CLK_HZ    = 100_000_000,
    parameter longint RST_US    = 6000,
    parameter longint DISC_US   = 200000,
    parameter longint SETTLE_US = 100000,
    parameter longint DEB_US    = 1000,
    parameter int     DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rst_req,
    input  logic          disc_req,
    output logic          mod_rst_n,
    output logic          mod_disc_n,
    input  logic          mod_link,
    output logic          connected,
    output logic          busy,
    input  logic          loc_tx_valid,
    input  logic [DW-1:0] loc_tx_data,
    output logic          mod_tx_valid,
    output logic [DW-1:0] mod_tx_data,
    input  logic          mod_rx_valid,
    input  logic [DW-1:0] mod_rx_data,
    output logic          loc_rx_valid,
    output logic [DW-1:0] loc_rx_data
);
    localparam int RST_CYC    = us_to_cyc(CLK_HZ, RST_US);
    localparam int DISC_CYC   = us_to_cyc(CLK_HZ, DISC_US);
    localparam int SETTLE_CYC = us_to_cyc(CLK_HZ, SETTLE_US);
    localparam int DEB_CYC    = us_to_cyc(CLK_HZ, DEB_US);
    localparam int NLANE      = 2;

    logic mod_rst_n_w;

    wlink_pulse_ctl #(
        .RST_CYC (RST_CYC),
        .DISC_CYC(DISC_CYC)
    ) i_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_req   (rst_req),
        .disc_req  (disc_req),
        .mod_rst_n (mod_rst_n_w),
        .mod_disc_n(mod_disc_n),
        .busy      (busy)
    );

    assign mod_rst_n = mod_rst_n_w;

    wlink_link_mon #(
        .SETTLE_CYC(SETTLE_CYC),
        .DEB_CYC   (DEB_CYC)
    ) i_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .mod_in_rst(~mod_rst_n_w),
        .link_raw  (mod_link),
        .connected (connected)
    );

    // Lane 0: local -> module, lane 1: module -> local.
    logic          lane_iv [NLANE];
    logic [DW-1:0] lane_id [NLANE];
    logic          lane_ov [NLANE];
    logic [DW-1:0] lane_od [NLANE];

    assign lane_iv[0] = loc_tx_valid;
    assign lane_id[0] = loc_tx_data;
    assign lane_iv[1] = mod_rx_valid;
    assign lane_id[1] = mod_rx_data;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        wlink_lane #(.DW(DW)) i_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (connected),
            .in_v (lane_iv[g]),
            .in_d (lane_id[g]),
            .out_v(lane_ov[g]),
            .out_d(lane_od[g])
        );
    end

    assign mod_tx_valid = lane_ov[0];
    assign mod_tx_data  = lane_od[0];
    assign loc_rx_valid = lane_ov[1];
    assign loc_rx_data  = lane_od[1];

    assert_busy_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy == (!mod_rst_n || !mod_disc_n));

    assert_reset_over_disc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && rst_req && disc_req |=> !mod_rst_n && mod_disc_n);

endmodule

// File: tb/test_wlink_seq.sv
module test_wlink_seq;
    localparam int DW       = 8;
    localparam int RST_CYC  = 60;
    localparam int DISC_CYC = 2000;
    localparam int SETTLE   = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rst_req = 1'b0, disc_req = 1'b0, mod_link = 1'b0;
    logic loc_tx_valid = 1'b0, mod_rx_valid = 1'b0;
    logic [DW-1:0] loc_tx_data = '0, mod_rx_data = '0;
    logic mod_rst_n, mod_disc_n, connected, busy;
    logic mod_tx_valid, loc_rx_valid;
    logic [DW-1:0] mod_tx_data, loc_rx_data;

    int total = 0;
    int bad = 0;
    logic [DW-1:0] exp_up[$];
    logic [DW-1:0] exp_dn[$];

    always #5 clk = ~clk;

    wlink_seq #(
        .CLK_HZ(10000), .RST_US(6000), .DISC_US(200000),
        .SETTLE_US(100000), .DEB_US(1000), .DW(DW)
    ) i_wlink_seq (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .disc_req(disc_req),
        .mod_rst_n(mod_rst_n), .mod_disc_n(mod_disc_n), .mod_link(mod_link),
        .connected(connected), .busy(busy),
        .loc_tx_valid(loc_tx_valid), .loc_tx_data(loc_tx_data),
        .mod_tx_valid(mod_tx_valid), .mod_tx_data(mod_tx_data),
        .mod_rx_valid(mod_rx_valid), .mod_rx_data(mod_rx_data),
        .loc_rx_valid(loc_rx_valid), .loc_rx_data(loc_rx_data)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard monitors: pop on every output byte.
    always @(negedge clk) begin
        if (rst_n && mod_tx_valid) begin
            if (exp_up.size() == 0) check("R9 up unexpected byte", int'(mod_tx_data), -1);
            else check("R8 up byte", int'(mod_tx_data), int'(exp_up.pop_front()));
        end
        if (rst_n && loc_rx_valid) begin
            if (exp_dn.size() == 0) check("R9 dn unexpected byte", int'(loc_rx_data), -1);
            else check("R8 dn byte", int'(loc_rx_data), int'(exp_dn.pop_front()));
        end
    end

    // Drivers: push the expected items when the link flag is up.
    task automatic burst(input int n, input logic [DW-1:0] seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            loc_tx_valid = 1'b1;
            loc_tx_data  = seed + DW'(i * 3);
            mod_rx_valid = (i % 2 == 0);
            mod_rx_data  = ~seed ^ DW'(i * 5);
            if (connected) begin
                exp_up.push_back(loc_tx_data);
                if (mod_rx_valid) exp_dn.push_back(mod_rx_data);
            end
        end
        @(negedge clk);
        loc_tx_valid = 1'b0;
        mod_rx_valid = 1'b0;
    endtask

    // Count negedges while the module reset pin is low, starting now.
    task automatic low_len_rst(output int n);
        n = 0;
        while (!mod_rst_n) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        check("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic rst_seen;
        mod_link = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset pin low in reset", int'(mod_rst_n), 0);
        check("R5 busy in reset", int'(busy), 1);
        check("R6 connected low in reset", int'(connected), 0);
        rst_n = 1'b1;
        low_len_rst(n);
        check("R1 power-up pulse width", n, RST_CYC);
        check("R5 busy after pulse", int'(busy), 0);

        // R6: settle gate, then R7 debounce of the already-high status.
        burst(4, 8'h10);
        repeat (1005 - 6) @(negedge clk);
        check("R6 connected low before settle", int'(connected), 0);
        repeat (7) @(negedge clk);
        check("R7 connected after settle+debounce", int'(connected), 1);

        // R8: traffic while connected.
        burst(12, 8'h40);
        burst(1, 8'hFF);
        repeat (3) @(negedge clk);

        // R7: short glitch ignored, long drop accepted.
        mod_link = 1'b0;
        repeat (5) @(negedge clk);
        mod_link = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 glitch ignored", int'(connected), 1);
        mod_link = 1'b0;
        repeat (8) @(negedge clk);
        check("R7 still up mid-debounce", int'(connected), 1);
        repeat (8) @(negedge clk);
        check("R7 drop after debounce", int'(connected), 0);

        // R9: bytes dropped while down.
        burst(6, 8'h80);
        repeat (3) @(negedge clk);
        check("R9 nothing pending", exp_up.size() + exp_dn.size(), 0);
        mod_link = 1'b1;
        repeat (20) @(negedge clk);
        check("R7 reconnect", int'(connected), 1);

        // R3 and R4: disconnect pulse, second requests ignored.
        @(negedge clk);
        disc_req = 1'b1;
        @(negedge clk);
        disc_req = 1'b0;
        check("R3 disc pin low", int'(mod_disc_n), 0);
        check("R5 busy during disc", int'(busy), 1);
        n = 0;
        rst_seen = 1'b0;
        while (!mod_disc_n) begin
            n++;
            if (!mod_rst_n) rst_seen = 1'b1;
            if (n == 500) begin
                disc_req = 1'b1;
                rst_req  = 1'b1;
            end else begin
                disc_req = 1'b0;
                rst_req  = 1'b0;
            end
            @(negedge clk);
        end
        disc_req = 1'b0;
        rst_req  = 1'b0;
        check("R3 disc pulse width", n, DISC_CYC);
        check("R4 reset ignored during disc", int'(rst_seen), 0);
        repeat (3) @(negedge clk);
        check("R4 no restart after disc", int'(mod_disc_n) + int'(mod_rst_n), 2);
        check("R5 busy cleared", int'(busy), 0);

        // R2 and R4: simultaneous requests, reset wins.
        @(negedge clk);
        rst_req  = 1'b1;
        disc_req = 1'b1;
        @(negedge clk);
        rst_req  = 1'b0;
        disc_req = 1'b0;
        check("R4 reset wins", int'(mod_rst_n), 0);
        check("R4 no disc with reset", int'(mod_disc_n), 1);
        @(negedge clk);
        check("R2 connected cleared", int'(connected), 0);
        burst(3, 8'hC0);
        n = RST_CYC + 10;
        begin
            int m;
            low_len_rst(m);
            n = m + 5;
        end
        check("R2 requested pulse width", n, RST_CYC);
        check("R6 connected low after reset", int'(connected), 0);
        repeat (1005) @(negedge clk);
        check("R6 still low before settle", int'(connected), 0);
        repeat (7) @(negedge clk);
        check("R6 up again after settle", int'(connected), 1);
        burst(5, 8'h22);
        repeat (4) @(negedge clk);
        check("R8 scoreboard drained", exp_up.size() + exp_dn.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule